// File: doc/BRIEF.md
# Byte-Windowed Instruction RAM Loader

This block lets a host that only has a byte-wide register port fill and inspect a RAM of 32-bit instruction words. The host first programs a 9-bit word address by writing a low address register (bits 7:0) and a high address register (bit 8 only). It then moves one byte per access through a single data register. The first byte of a word is the least significant one.

On writes, the first three bytes are held in a gather buffer. The RAM word changes only when the fourth byte arrives, and then the word address steps forward. A host can therefore stream any number of consecutive words after programming the address once. Reads walk the lanes of the addressed word in the same order and step the address after the fourth byte. Any change to the address registers restarts the lane sequence at the least significant byte.

Top module: `iram_byte_loader`

## Requirements
- R1: After reset the word address is 0, the lane index is 0, and both address registers read back 0.
- R2: Select 1 is the low address register and holds address bits 7:0. Select 2 is the high address register: only bit 0 of a write is kept (address bit 8), and bits 7:1 read back as 0.
- R3: A write to either address register returns the lane index to 0, so the next data access uses the least significant byte.
- R4: Data writes (select 0) are taken least significant byte first. The RAM word at the current address is replaced by the four gathered bytes only when the fourth byte is written. One to three bytes followed by an address change leave that word unchanged.
- R5: The word address stays put during the first three byte accesses and rises by one right after the fourth.
- R6: A data read (select 0) returns byte lane k, bits 8k+7:8k, of the word at the current address, where k is the lane index. The read advances the lane exactly as a write does, including the address step after lane 3.
- R7: The word address wraps from 511 to 0 when it steps forward, for reads and for writes.
- R8: Select 3 maps to nothing. Writes to it change no state, reads from it return 0 and do not advance the lane. When a write and a read strobe arrive in the same cycle, the write is performed and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 address low, 2 address high, 3 unmapped |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; advances the lane when the data register is selected |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data of the selected register, valid in the same cycle |

## Verification
On every cycle the assertions check the lane and address sequencing. They confirm that an address-register write leaves the lane at 0 and that a data access moves the lane by one. They confirm that the address holds except after the last lane, where it steps by one modulo 512. They also confirm that idle or unmapped cycles leave both the lane and the address unchanged, and that the high address register reads back with zero upper bits. Only the bench's scenarios can show which bytes land in which lanes of which RAM word, and that partial words never reach the RAM. The full-memory stream, the wrap from 511 to 0, and the read-back through the same port also depend on the bench.

// File: rtl/iram_byte_loader.sv
module iram_byte_loader #(
  parameter int ADDR_W     = 9,
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int LANE_W    = $clog2(WORD_BYTES);
  localparam int WORD_W    = 8 * WORD_BYTES;
  localparam int GATHER_W  = WORD_W - 8;
  localparam int HI_W      = ADDR_W - 8;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ALO  = 2'd1;
  localparam logic [1:0] SEL_AHI  = 2'd2;

  logic [ADDR_W-1:0]   addr;
  logic [LANE_W-1:0]   lane;
  logic [GATHER_W-1:0] gather;
  logic [WORD_W-1:0]   mem [DEPTH];
  logic [WORD_W-1:0]   cur_word;

  wire data_wr  = reg_wr && (reg_sel == SEL_DATA);
  wire data_rd  = reg_rd && !reg_wr && (reg_sel == SEL_DATA);
  wire data_acc = data_wr || data_rd;
  wire addr_wr  = reg_wr && (reg_sel == SEL_ALO || reg_sel == SEL_AHI);
  wire at_last  = (lane == LAST_LANE);
  wire commit   = data_wr && at_last;

  assign cur_word = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      lane <= '0;
    end else if (addr_wr) begin
      lane <= '0;
      if (reg_sel == SEL_ALO) addr[7:0] <= reg_wdata;
      else                    addr[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
    end else if (data_acc) begin
      lane <= lane + 1'b1;
      if (at_last) addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gather <= '0;
    else if (data_wr && !at_last) gather[int'(lane)*8 +: 8] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (commit) mem[addr] <= {reg_wdata, gather};
  end

  always_comb begin
    case (reg_sel)
      SEL_DATA: reg_rdata = cur_word[int'(lane)*8 +: 8];
      SEL_ALO:  reg_rdata = addr[7:0];
      SEL_AHI:  reg_rdata = {{(8-HI_W){1'b0}}, addr[ADDR_W-1:8]};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assert_lane_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> lane == '0);

  assert_lane_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !addr_wr) |=> lane == LANE_W'($past(lane) + 1'b1));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !at_last) |=> $stable(addr));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && at_last) |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !(reg_rd && reg_sel == SEL_DATA)) |=> ($stable(addr) && $stable(lane)));

  assert_hi_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_AHI) |-> reg_rdata[7:HI_W] == '0);
endmodule

// File: tb/iram_byte_loader_tb.sv
module iram_byte_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [512];

  always #10 clk = ~clk;

  iram_byte_loader dut_i (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] pat(input int i);
    return i * 32'h9E3779B1 + 32'h13579BDF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1; reg_wr = 1'b0;
    #2 v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b0; reg_wr = 1'b0;
    #2 v = reg_rdata;
  endtask

  task automatic set_addr(input int a);
    wr(2'd1, a[7:0]);
    wr(2'd2, {7'd0, a[8]});
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(2'd0, w[b*8 +: 8]);
  endtask

  task automatic rd_word(output logic [31:0] w);
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      rd(2'd0, v);
      w[b*8 +: 8] = v;
    end
  endtask

  task automatic get_addr(output int a);
    logic [7:0] lo, hi;
    peek(2'd1, lo);
    peek(2'd2, hi);
    a = {hi[0], lo};
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [31:0] w;
    int a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    peek(2'd1, v); chk(v == 8'h00, "R1 addr low", v, 0);
    peek(2'd2, v); chk(v == 8'h00, "R1 addr high", v, 0);

    // R2: address registers
    wr(2'd1, 8'hA5); wr(2'd2, 8'hFF);
    peek(2'd1, v); chk(v == 8'hA5, "R2 low", v, 8'hA5);
    peek(2'd2, v); chk(v == 8'h01, "R2 high bit0 only", v, 8'h01);

    // R4 R6 R7: stream all 512 words, address wraps to 0, read all back
    set_addr(0);
    for (int i = 0; i < 512; i++) begin
      model[i] = pat(i);
      wr_word(model[i]);
    end
    get_addr(a); chk(a == 0, "R7 write wrap", a, 0);
    for (int i = 0; i < 512; i++) begin
      rd_word(w);
      chk(w == model[i], "R6 R4 read word", w, model[i]);
    end
    get_addr(a); chk(a == 0, "R7 read wrap", a, 0);

    // R5: address holds until fourth byte
    set_addr(10);
    for (int b = 0; b < 3; b++) begin
      wr(2'd0, 8'h11 * (b + 1));
      get_addr(a); chk(a == 10, "R5 hold", a, 10);
    end
    wr(2'd0, 8'h44);
    model[10] = 32'h44332211;
    get_addr(a); chk(a == 11, "R5 step", a, 11);
    set_addr(10); rd_word(w); chk(w == model[10], "R4 lane order", w, model[10]);

    // R4 R3: partial write not committed, address write resets lane
    set_addr(300);
    wr(2'd0, 8'hDE); wr(2'd0, 8'hAD);
    set_addr(300);
    rd_word(w); chk(w == model[300], "R4 partial ignored", w, model[300]);
    set_addr(301);
    rd(2'd0, v); rd(2'd0, v);
    set_addr(301);
    rd(2'd0, v); chk(v == model[301][7:0], "R3 lane reset", v, model[301][7:0]);

    // R7: wrap from 511 on a single write
    set_addr(511);
    wr_word(32'hCAFEF00D); model[511] = 32'hCAFEF00D;
    get_addr(a); chk(a == 0, "R7 wrap 511", a, 0);
    set_addr(511); rd_word(w); chk(w == 32'hCAFEF00D, "R7 word 511", w, 32'hCAFEF00D);

    // R8: unmapped select and write-over-read
    set_addr(30);
    rd(2'd0, v); chk(v == model[30][7:0], "R6 lane0", v, model[30][7:0]);
    wr(2'd3, 8'h5A);
    rd(2'd3, v); chk(v == 8'h00, "R8 unmapped read", v, 0);
    get_addr(a); chk(a == 30, "R8 addr kept", a, 30);
    for (int b = 1; b < 4; b++) begin
      rd(2'd0, v); chk(v == model[30][b*8 +: 8], "R8 lane kept", v, model[30][b*8 +: 8]);
    end
    get_addr(a); chk(a == 31, "R6 read step", a, 31);
    set_addr(40);
    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 8'h77; reg_wr = 1'b1; reg_rd = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0; reg_rd = 1'b0;
    wr(2'd0, 8'h66); wr(2'd0, 8'h55); wr(2'd0, 8'h44);
    model[40] = 32'h44556677;
    get_addr(a); chk(a == 41, "R8 write wins", a, 41);
    set_addr(40); rd_word(w); chk(w == model[40], "R8 write wins data", w, model[40]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule